// File: doc/BRIEF.md
# Software Write-Protection Sequencer

This block sits between a host write port and the page-write controller of a byte-wide, 13-bit-address nonvolatile memory. It watches every host write strobe together with its address and data. It decides whether the strobe is a command step or a real data write, and it drives a qualified strobe that tells the downstream controller to load the byte. The downstream controller takes address and data straight from the host bus, so only the strobe is gated here.

Two command sequences are recognised. Both start with the same two steps. A three-step arming prefix turns protection on and opens a short load window. A six-step release sequence turns protection off. While protection is off, plain writes pass through. While it is on, a data write reaches the array only inside the load window that follows an arming prefix. The window closes after a set number of bytes or after a set number of idle cycles. The mode flag is volatile and reads as off after reset.

Top module: `swp_guard`

## Requirements
- R1: After reset `prot_on` is 0. A strobe never produces `q_stb` unless `wr_stb` is high in the same cycle.
- R2: With `prot_on` at 0 and no sequence in progress, a strobe whose pair is not the lead step (address 0x1555, data 0xAA) raises `q_stb` combinationally in the same cycle.
- R3: The arming prefix is the pairs 0x1555/0xAA, 0x0AAA/0x55 and 0x1555/0xA0, issued in that order. `q_stb` stays low for all three. `prot_on` reads 1 from the clock edge that accepts the third step.
- R4: With `prot_on` at 1 and no open load window, a data write gives no `q_stb`.
- R5: After an arming prefix, up to PAGE_BYTES strobes are forwarded as data whatever their address and data, even when a pair equals a command step. The next strobe after that is judged as outside the window.
- R6: The load window closes after WINDOW_CYC consecutive cycles with no strobe. A strobe that arrives after WINDOW_CYC-1 idle cycles is still forwarded.
- R7: The release sequence is 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20. None of the six raises `q_stb`. `prot_on` reads 0 from the edge that accepts the sixth step. An incomplete release leaves `prot_on` unchanged.
- R8: A pair that does not match the expected next step abandons the sequence. The same pair is then judged afresh: if it is the lead step it starts a new sequence, otherwise it is a data write (R2/R4). Command steps that were absorbed before an abandoned sequence are not forwarded.
- R9: The third step selects the branch. 0xA0 at 0x1555 arms, 0x80 at 0x1555 continues the release, and any other pair abandons the sequence per R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Host write strobe, one cycle per byte |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| q_stb | output | 1 | Qualified strobe to the page-write controller |
| prot_on | output | 1 | Protection mode flag |

## Verification
Two things can land in one cycle: the expiry of the load window and a data strobe that arrives on its final idle count. The strobe must win. The bench arms protection and then waits exactly WINDOW_CYC-1 idle cycles before a write, which must be forwarded. It then waits WINDOW_CYC idle cycles before the next write, which must be dropped. Counting the page limit works the same way: the last permitted byte and the close of the window share a cycle, and the byte just after it is judged by the plain protected rule.

// File: rtl/swp_pkg.sv
package swp_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_K1   = 3'd1,
      SQ_K2   = 3'd2,
      SQ_OPEN = 3'd3,
      SQ_U3   = 3'd4,
      SQ_U4   = 3'd5,
      SQ_U5   = 3'd6
   } sq_state_t;

   localparam int NKEYS     = 5;
   localparam int KY_LEAD   = 0;
   localparam int KY_SECOND = 1;
   localparam int KY_ARM    = 2;
   localparam int KY_UNLOCK = 3;
   localparam int KY_FINAL  = 4;

   // alternating address pattern, bit 0 set when even_bits is 1
   function automatic logic [31:0] alt_addr(input int aw, input bit even_bits);
      logic [31:0] v;
      v = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < aw && (((i % 2) == 0) == even_bits)) v[i] = 1'b1;
      end
      return v;
   endfunction

   function automatic logic [31:0] key_addr(input int aw, input int idx);
      return (idx == KY_SECOND) ? alt_addr(aw, 1'b0) : alt_addr(aw, 1'b1);
   endfunction

   function automatic logic [31:0] key_data(input int idx);
      case (idx)
         KY_LEAD:   return 32'h0000_00AA;
         KY_SECOND: return 32'h0000_0055;
         KY_ARM:    return 32'h0000_00A0;
         KY_UNLOCK: return 32'h0000_0080;
         default:   return 32'h0000_0020;
      endcase
   endfunction

endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
   import swp_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [NKEYS-1:0]  hit
);

   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      localparam logic [31:0]       KA32 = key_addr(ADDR_W, k);
      localparam logic [31:0]       KD32 = key_data(k);
      localparam logic [ADDR_W-1:0] KA   = KA32[ADDR_W-1:0];
      localparam logic [DATA_W-1:0] KD   = KD32[DATA_W-1:0];
      assign hit[k] = (addr == KA) && (data == KD);
   end

endmodule

// File: rtl/swp_arm_timer.sv
module swp_arm_timer #(
   parameter int PAGE_BYTES = 64,
   parameter int WINDOW_CYC = 25000,
   parameter bit USE_WINDOW = 1'b1,
   localparam int CNT_W  = $clog2(PAGE_BYTES + 1),
   localparam int IDLE_W = $clog2(WINDOW_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             stb,
   output logic             page_last,
   output logic             idle_expire,
   output logic [CNT_W-1:0] page_cnt
);

   localparam logic [CNT_W-1:0] PAGE_TOP = CNT_W'(PAGE_BYTES - 1);

   assign page_last = armed && (page_cnt == PAGE_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      page_cnt <= '0;
      else if (!armed)                 page_cnt <= '0;
      else if (stb && page_last)       page_cnt <= '0;
      else if (stb)                    page_cnt <= page_cnt + 1'b1;
   end

   if (USE_WINDOW) begin : g_window
      localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(WINDOW_CYC - 1);
      logic [IDLE_W-1:0] idle_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              idle_cnt <= '0;
         else if (!armed || stb)  idle_cnt <= '0;
         else                     idle_cnt <= idle_cnt + 1'b1;
      end

      assign idle_expire = armed && !stb && (idle_cnt == IDLE_TOP);
   end else begin : g_no_window
      assign idle_expire = 1'b0;
   end

endmodule

// File: rtl/swp_guard.sv
module swp_guard
   import swp_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 64,
   parameter int WINDOW_CYC = 25000,
   parameter bit USE_WINDOW = 1'b1,
   localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              q_stb,
   output logic              prot_on
);

   initial begin
      if (ADDR_W < 2 || ADDR_W > 32) $fatal(1, "swp_guard: ADDR_W out of range");
      if (DATA_W != 8)               $fatal(1, "swp_guard: DATA_W must be 8");
      if (PAGE_BYTES < 1)            $fatal(1, "swp_guard: PAGE_BYTES must be positive");
      if (WINDOW_CYC < 1)            $fatal(1, "swp_guard: WINDOW_CYC must be positive");
   end

   sq_state_t        state_q, state_d;
   logic [NKEYS-1:0] hit;
   logic             page_last, idle_expire;
   logic [CNT_W-1:0] page_cnt;
   logic             set_p, clr_p, fwd;

   swp_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
      .addr (wr_addr),
      .data (wr_data),
      .hit  (hit)
   );

   swp_arm_timer #(
      .PAGE_BYTES (PAGE_BYTES),
      .WINDOW_CYC (WINDOW_CYC),
      .USE_WINDOW (USE_WINDOW)
   ) timer_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .armed       (state_q == SQ_OPEN),
      .stb         (wr_stb),
      .page_last   (page_last),
      .idle_expire (idle_expire),
      .page_cnt    (page_cnt)
   );

   always_comb begin
      state_d = state_q;
      set_p   = 1'b0;
      clr_p   = 1'b0;
      fwd     = 1'b0;
      if (wr_stb) begin
         unique case (state_q)
            SQ_OPEN: begin
               fwd = 1'b1;
               if (page_last) state_d = SQ_IDLE;
            end
            SQ_K1: if (hit[KY_SECOND]) state_d = SQ_K2;
            SQ_K2: begin
               if (hit[KY_ARM]) begin
                  state_d = SQ_OPEN;
                  set_p   = 1'b1;
               end else if (hit[KY_UNLOCK]) begin
                  state_d = SQ_U3;
               end
            end
            SQ_U3: if (hit[KY_LEAD])   state_d = SQ_U4;
            SQ_U4: if (hit[KY_SECOND]) state_d = SQ_U5;
            SQ_U5: begin
               if (hit[KY_FINAL]) begin
                  state_d = SQ_IDLE;
                  clr_p   = 1'b1;
               end
            end
            default: ;
         endcase
         // mismatch or idle: judge the pair afresh as a first step
         if (state_d == state_q && state_q != SQ_OPEN && !(state_q == SQ_K1 && hit[KY_SECOND])) begin
            if (hit[KY_LEAD]) begin
               state_d = SQ_K1;
            end else begin
               state_d = SQ_IDLE;
               fwd     = !prot_on;
            end
         end
      end else if (idle_expire) begin
         state_d = SQ_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         prot_on <= 1'b0;
      end else begin
         state_q <= state_d;
         if (set_p)      prot_on <= 1'b1;
         else if (clr_p) prot_on <= 1'b0;
      end
   end

   assign q_stb = fwd;

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk
   import swp_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 64,
   localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              q_stb,
   input logic              prot_on,
   input sq_state_t         state_q,
   input logic [CNT_W-1:0]  page_cnt
);

   localparam logic [31:0]       KODD32 = key_addr(ADDR_W, KY_LEAD);
   localparam logic [ADDR_W-1:0] KODD   = KODD32[ADDR_W-1:0];

   logic on_odd;
   assign on_odd = wr_stb && (wr_addr == KODD);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      q_stb |-> wr_stb);

   a_r2_plain_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_on && state_q == SQ_IDLE && wr_stb && !(on_odd && wr_data == 8'hAA)) |-> q_stb);

   a_r3_rise_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_on) |-> $past(on_odd && wr_data == 8'hA0));

   a_r3_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_K2 && on_odd && wr_data == 8'hA0) |=> (state_q == SQ_OPEN && prot_on));

   a_r4_protected_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && state_q == SQ_IDLE && wr_stb) |-> !q_stb);

   a_r5_window_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_OPEN && wr_stb) |-> q_stb);

   a_r5_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
      page_cnt < CNT_W'(PAGE_BYTES));

   a_r7_fall_on_final: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_on) |-> $past(on_odd && wr_data == 8'h20));

   a_r7_final_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_U5 && on_odd && wr_data == 8'h20) |-> !q_stb);

endmodule

bind swp_guard swp_guard_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .PAGE_BYTES (PAGE_BYTES)
) chk_i (.*);

// File: tb/swp_guard_tb.sv
module swp_guard_tb_top;

   localparam int AW = 13;
   localparam int DW = 8;
   localparam int PB = 4;
   localparam int WC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          q_stb, prot_on;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   swp_guard #(
      .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (PB), .WINDOW_CYC (WC), .USE_WINDOW (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .wr_addr (wr_addr),
      .wr_data (wr_data), .q_stb (q_stb), .prot_on (prot_on)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one strobe; q_stb sampled before the capturing edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic exp_q, input string req);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      #1 check(req, q_stb, exp_q);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_stb = 1'b0;
      end
   endtask

   // consumes one idle cycle
   task automatic chk_prot(input logic exp, input string req);
      @(negedge clk);
      wr_stb = 1'b0;
      #1 check(req, prot_on, exp);
   endtask

   task automatic arm(input string req);
      wr(13'h1555, 8'hAA, 1'b0, req);
      wr(13'h0AAA, 8'h55, 1'b0, req);
      wr(13'h1555, 8'hA0, 1'b0, req);
   endtask

   task automatic release_seq(input string req);
      wr(13'h1555, 8'hAA, 1'b0, req);
      wr(13'h0AAA, 8'h55, 1'b0, req);
      wr(13'h1555, 8'h80, 1'b0, req);
      wr(13'h1555, 8'hAA, 1'b0, req);
      wr(13'h0AAA, 8'h55, 1'b0, req);
      wr(13'h1555, 8'h20, 1'b0, req);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 check("R1 reset flag", prot_on, 1'b0);
      check("R1 no strobe at rest", q_stb, 1'b0);
      rst_n = 1'b1;
      wr(13'h0010, 8'h01, 1'b1, "R1 first plain write");

      // R2 sweep, unprotected: lead pair is skipped so no sequence starts
      for (int a = 0; a < 512; a++) begin
         logic [AW-1:0] ad;
         logic [DW-1:0] da;
         ad = AW'(a * 17);
         da = DW'(a * 37 + 3);
         if (!(ad == 13'h1555 && da == 8'hAA)) wr(ad, da, 1'b1, "R2 sweep pass");
      end
      idle(1);

      release_seq("R7 release while off");
      chk_prot(1'b0, "R7 stays off");

      // R3 arm, R5 page
      arm("R3 prefix swallowed");
      chk_prot(1'b1, "R3 flag set");
      wr(13'h0100, 8'h11, 1'b1, "R5 byte 1");
      wr(13'h1555, 8'hAA, 1'b1, "R5 command pair as data");
      wr(13'h0102, 8'h33, 1'b1, "R5 byte 3");
      wr(13'h0103, 8'h44, 1'b1, "R5 byte 4 last");
      wr(13'h0104, 8'h55, 1'b0, "R5 beyond page");

      // R4 sweep, protected
      for (int a = 0; a < 256; a++) begin
         logic [AW-1:0] ad;
         ad = AW'(a * 29 + 5);
         if (ad != 13'h1555) wr(ad, DW'(a), 1'b0, "R4 protected drop");
      end
      idle(1);

      // R6 window edges
      arm("R6 arm");
      idle(WC - 1);
      wr(13'h0200, 8'h01, 1'b1, "R6 strobe on last idle count");
      idle(WC);
      wr(13'h0201, 8'h02, 1'b0, "R6 window closed");
      arm("R6 arm again");
      idle(WC);
      wr(13'h0202, 8'h03, 1'b0, "R6 closed from arm");

      // R8 restart with repeated lead
      wr(13'h1555, 8'hAA, 1'b0, "R8 lead");
      wr(13'h1555, 8'hAA, 1'b0, "R8 lead again");
      wr(13'h0AAA, 8'h55, 1'b0, "R8 second");
      wr(13'h1555, 8'hA0, 1'b0, "R8 arm");
      wr(13'h0300, 8'h05, 1'b1, "R8 restarted prefix works");
      idle(WC);

      // R9 bad third step, protected
      wr(13'h1555, 8'hAA, 1'b0, "R9 lead");
      wr(13'h0AAA, 8'h55, 1'b0, "R9 second");
      wr(13'h1555, 8'h81, 1'b0, "R9 bad branch dropped");
      wr(13'h0301, 8'h06, 1'b0, "R9 not armed");

      // R7 incomplete release keeps protection
      wr(13'h1555, 8'hAA, 1'b0, "R7 part");
      wr(13'h0AAA, 8'h55, 1'b0, "R7 part");
      wr(13'h1555, 8'h80, 1'b0, "R7 part");
      wr(13'h1555, 8'hAA, 1'b0, "R7 part");
      wr(13'h0AAA, 8'h55, 1'b0, "R7 part");
      wr(13'h1555, 8'h21, 1'b0, "R7 wrong final");
      chk_prot(1'b1, "R7 incomplete keeps on");

      release_seq("R7 release swallowed");
      chk_prot(1'b0, "R7 flag cleared");
      wr(13'h0400, 8'h07, 1'b1, "R7 plain after release");

      // R8 unprotected mismatch is forwarded
      wr(13'h1555, 8'hAA, 1'b0, "R8 lead absorbed");
      wr(13'h0123, 8'h09, 1'b1, "R8 mismatch forwarded");
      // R9 unprotected bad branch forwarded
      wr(13'h1555, 8'hAA, 1'b0, "R9 lead");
      wr(13'h0AAA, 8'h55, 1'b0, "R9 second");
      wr(13'h1555, 8'h81, 1'b1, "R9 bad branch forwarded");
      chk_prot(1'b0, "R9 flag unchanged");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule